// File: doc/BRIEF.md
# Access Violation Monitor with Fault Capture

This block sits behind a memory permission checker and watches its deny signal. When a denied access arrives while the monitor is enabled and no earlier fault is pending, the block records what the access looked like: its address, the world (privilege domain) that issued it as a one-hot code, whether it was a write or a read, and one side-specific field. It then raises a level interrupt toward the interrupt controller. The permission decision itself and the routing of the interrupt are handled elsewhere.

Software controls the monitor through a small control write port and reads the captured fields and control bits back through parallel status outputs. The control word has three bits: bit 0 enables capture, bit 1 is the clear control and bit 2 is a lock. Clearing is a two-step sequence. Software sets the clear bit, which wipes the interrupt and all captured fields and keeps them wiped while it stays high, and then writes it back to zero to re-arm the monitor. Once the lock bit is set, the enable and clear bits are frozen until reset.

A parameter selects the variant. The instruction-side variant records whether the fault came from a load/store or from an instruction fetch. The data-side variant records the byte-enable mask of the faulting access instead.

Top module: `viol_capture`

## Requirements
- R1: After reset the interrupt, every captured field and the enable, clear and lock bits are all zero.
- R2: While the enable bit (control bit 0) is zero, a denied access sets no interrupt and leaves the captured fields unchanged.
- R3: A denied access taken while enabled, not clearing and with no pending interrupt raises the interrupt on the next clock and captures its address. World 0 is captured as 2'b01 and world 1 as 2'b10.
- R4: The captured direction bit is 1 for a denied write and 0 for a denied read.
- R5: The instruction-side variant (DATA_SIDE=0) captures the load/store flag, 1 for load/store and 0 for fetch, and always reports a zero byte mask.
- R6: The data-side variant (DATA_SIDE=1) captures the byte-enable mask and always reports a zero load/store flag.
- R7: Only the first fault is recorded. While the interrupt is pending, later faults do not change any captured field.
- R8: While the clear bit (control bit 1) is one, the interrupt and every captured field read zero one clock later and no fault is captured. After the clear bit returns to zero, the next fault is captured again.
- R9: Writing the lock bit (control bit 2) as one sets it. It stays set until reset, and while it is set, control writes change neither the enable bit nor the clear bit. A write that sets the lock still applies its own enable and clear bits.
- R10: The interrupt is a level signal. It stays high on every clock until a clear sequence removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flt_valid | input | 1 | Permission checker denied the current access |
| flt_addr | input | AW | Address of the denied access |
| flt_world | input | 1 | Issuing world: 0 or 1 |
| flt_write | input | 1 | 1 for a write, 0 for a read |
| flt_ls | input | 1 | 1 for load/store, 0 for instruction fetch |
| flt_be | input | BEW | Byte enables of the denied access |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 3 | Control word: bit 0 enable, bit 1 clear, bit 2 lock |
| ctl_en | output | 1 | Enable bit readback |
| ctl_clr | output | 1 | Clear bit readback |
| ctl_lock | output | 1 | Lock bit readback |
| irq | output | 1 | Level interrupt, high while a fault is pending |
| cap_addr | output | AW | Captured fault address |
| cap_world | output | 2 | Captured world, one-hot |
| cap_write | output | 1 | Captured direction |
| cap_ls | output | 1 | Captured load/store flag (instruction side) |
| cap_be | output | BEW | Captured byte enables (data side) |

## Verification
A corrupted pending flag shows at the ports within one clock. Either the interrupt drops without a clear sequence, or a second fault overwrites the captured address, which the bench sees at the next sample. A wrong control bit shows up as a fault that is captured or missed against the expected enable state, or as a clear that works while locked. The bench drives both variants from the same stimulus, so a field that is captured on the wrong side appears as a non-zero value on the side that must hold zero.

// File: rtl/viol_capture.sv
module viol_capture #(
  parameter int AW        = 32,
  parameter int BEW       = 4,
  parameter bit DATA_SIDE = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           flt_valid,
  input  logic [AW-1:0]  flt_addr,
  input  logic           flt_world,
  input  logic           flt_write,
  input  logic           flt_ls,
  input  logic [BEW-1:0] flt_be,
  input  logic           ctl_we,
  input  logic [2:0]     ctl_wdata,
  output logic           ctl_en,
  output logic           ctl_clr,
  output logic           ctl_lock,
  output logic           irq,
  output logic [AW-1:0]  cap_addr,
  output logic [1:0]     cap_world,
  output logic           cap_write,
  output logic           cap_ls,
  output logic [BEW-1:0] cap_be
);

  logic take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_en   <= 1'b0;
      ctl_clr  <= 1'b0;
      ctl_lock <= 1'b0;
    end else if (ctl_we) begin
      if (!ctl_lock) begin
        ctl_en  <= ctl_wdata[0];
        ctl_clr <= ctl_wdata[1];
      end
      ctl_lock <= ctl_lock | ctl_wdata[2];
    end
  end

  assign take = flt_valid & ctl_en & ~ctl_clr & ~irq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq       <= 1'b0;
      cap_addr  <= '0;
      cap_world <= 2'b00;
      cap_write <= 1'b0;
    end else if (ctl_clr) begin
      irq       <= 1'b0;
      cap_addr  <= '0;
      cap_world <= 2'b00;
      cap_write <= 1'b0;
    end else if (take) begin
      irq       <= 1'b1;
      cap_addr  <= flt_addr;
      cap_world <= flt_world ? 2'b10 : 2'b01;
      cap_write <= flt_write;
    end
  end

  generate
    if (DATA_SIDE) begin : g_data
      logic unused_ls;
      assign unused_ls = flt_ls;
      assign cap_ls    = 1'b0;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cap_be <= '0;
        else if (ctl_clr) cap_be <= '0;
        else if (take)    cap_be <= flt_be;
      end
    end else begin : g_instr
      logic unused_be;
      assign unused_be = ^flt_be;
      assign cap_be    = '0;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cap_ls <= 1'b0;
        else if (ctl_clr) cap_ls <= 1'b0;
        else if (take)    cap_ls <= flt_ls;
      end
    end
  endgenerate

  assert_no_capture_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_en && !irq) |=> !irq);

  assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && ctl_en && !ctl_clr && !irq) |=> irq);

  assert_world_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($countones(cap_world) == 1));

  assert_first_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ctl_clr) |=> ($stable(cap_addr) && $stable(cap_world) && $stable(cap_write)
                           && $stable(cap_ls) && $stable(cap_be)));

  assert_level_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ctl_clr) |=> irq);

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_clr |=> (!irq && cap_addr == '0 && cap_world == 2'b00));

  assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_lock |=> (ctl_lock && $stable(ctl_en) && $stable(ctl_clr)));

endmodule

// File: tb/test_viol_capture.sv
module test_viol_capture;
  localparam int AW  = 32;
  localparam int BEW = 4;

  typedef struct packed {
    logic [AW-1:0]  addr;
    logic           world;
    logic           wr;
    logic           ls;
    logic [BEW-1:0] be;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{addr: 32'h4038_0200, world: 1'b0, wr: 1'b1, ls: 1'b1, be: 4'hF},
    '{addr: 32'h3FC8_8000, world: 1'b1, wr: 1'b0, ls: 1'b0, be: 4'h1},
    '{addr: 32'h0000_0004, world: 1'b1, wr: 1'b1, ls: 1'b0, be: 4'hC},
    '{addr: 32'hFFFF_FFFC, world: 1'b0, wr: 1'b0, ls: 1'b1, be: 4'h6},
    '{addr: 32'h8000_0000, world: 1'b1, wr: 1'b1, ls: 1'b1, be: 4'h8}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flt_valid = 1'b0;
  logic [AW-1:0] flt_addr = '0;
  logic flt_world = 1'b0, flt_write = 1'b0, flt_ls = 1'b0;
  logic [BEW-1:0] flt_be = '0;
  logic ctl_we = 1'b0;
  logic [2:0] ctl_wdata = '0;

  logic i_en, i_clr, i_lock, i_irq, i_write, i_ls;
  logic [AW-1:0] i_addr;
  logic [1:0] i_world;
  logic [BEW-1:0] i_be;
  logic d_en, d_clr, d_lock, d_irq, d_write, d_ls;
  logic [AW-1:0] d_addr;
  logic [1:0] d_world;
  logic [BEW-1:0] d_be;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  viol_capture #(.AW(AW), .BEW(BEW), .DATA_SIDE(1'b0)) i_viol_capture (
    .clk, .rst_n, .flt_valid, .flt_addr, .flt_world, .flt_write, .flt_ls, .flt_be,
    .ctl_we, .ctl_wdata, .ctl_en(i_en), .ctl_clr(i_clr), .ctl_lock(i_lock),
    .irq(i_irq), .cap_addr(i_addr), .cap_world(i_world), .cap_write(i_write),
    .cap_ls(i_ls), .cap_be(i_be));

  viol_capture #(.AW(AW), .BEW(BEW), .DATA_SIDE(1'b1)) i_viol_capture_d (
    .clk, .rst_n, .flt_valid, .flt_addr, .flt_world, .flt_write, .flt_ls, .flt_be,
    .ctl_we, .ctl_wdata, .ctl_en(d_en), .ctl_clr(d_clr), .ctl_lock(d_lock),
    .irq(d_irq), .cap_addr(d_addr), .cap_world(d_world), .cap_write(d_write),
    .cap_ls(d_ls), .cap_be(d_be));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic en, input logic clr, input logic lock);
    @(negedge clk);
    ctl_we = 1'b1;
    ctl_wdata = {lock, clr, en};
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic fault(input vec_t v);
    @(negedge clk);
    flt_valid = 1'b1;
    flt_addr = v.addr; flt_world = v.world; flt_write = v.wr; flt_ls = v.ls; flt_be = v.be;
    @(negedge clk);
    flt_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  function automatic logic [1:0] onehot(input logic w);
    return w ? 2'b10 : 2'b01;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    vec_t a, b;
    do_reset();
    chk("R1 irq", {62'd0, i_irq, d_irq}, 64'd0);
    chk("R1 fields", {i_addr, i_world, i_write, i_ls, i_be}, 64'd0);
    chk("R1 ctl", {58'd0, i_en, i_clr, i_lock, d_en, d_clr, d_lock}, 64'd0);

    fault(VECS[0]);
    chk("R2 no irq when disabled", {62'd0, i_irq, d_irq}, 64'd0);
    chk("R2 addr unchanged", i_addr, 64'd0);

    wr_ctl(1'b1, 1'b0, 1'b0);
    for (int k = 0; k < NV; k++) begin
      fault(VECS[k]);
      chk("R3 irq", {62'd0, i_irq, d_irq}, 64'd3);
      chk("R3 addr", {i_addr, d_addr}, {VECS[k].addr, VECS[k].addr});
      chk("R3 world", {60'd0, i_world, d_world}, {60'd0, onehot(VECS[k].world), onehot(VECS[k].world)});
      chk("R4 direction", {62'd0, i_write, d_write}, {62'd0, VECS[k].wr, VECS[k].wr});
      chk("R5 ls instr side", {62'd0, i_ls, d_ls}, {62'd0, VECS[k].ls, 1'b0});
      chk("R6 be data side", {56'd0, i_be, d_be}, {56'd0, 4'h0, VECS[k].be});
      wr_ctl(1'b1, 1'b1, 1'b0);
      wr_ctl(1'b1, 1'b0, 1'b0);
    end

    a = VECS[1]; b = VECS[3];
    fault(a);
    repeat (20) @(negedge clk);
    chk("R10 irq held", {62'd0, i_irq, d_irq}, 64'd3);
    fault(b);
    chk("R7 addr keeps first", {i_addr, d_addr}, {a.addr, a.addr});
    chk("R7 fields keep first", {59'd0, i_world, i_write, i_ls}, {59'd0, onehot(a.world), a.wr, a.ls});
    chk("R7 be keeps first", d_be, {60'd0, a.be});

    wr_ctl(1'b1, 1'b1, 1'b0);
    fault(b);
    chk("R8 irq cleared while clear high", {62'd0, i_irq, d_irq}, 64'd0);
    chk("R8 fields zero while clear high", {i_addr, i_world, i_write, i_ls, i_be}, 64'd0);
    wr_ctl(1'b1, 1'b0, 1'b0);
    chk("R8 stays clear after release", {62'd0, i_irq, d_irq}, 64'd0);
    fault(b);
    chk("R8 capture re-armed", {i_addr, 31'd0, i_irq}, {b.addr, 32'd1});

    wr_ctl(1'b1, 1'b0, 1'b1);
    chk("R9 lock set", {61'd0, i_lock, i_en, i_clr}, {61'd0, 3'b110});
    wr_ctl(1'b0, 1'b1, 1'b0);
    chk("R9 en/clr frozen", {61'd0, i_lock, i_en, i_clr}, {61'd0, 3'b110});
    @(negedge clk);
    chk("R9 clear ignored while locked", {i_addr, 31'd0, i_irq}, {b.addr, 32'd1});

    do_reset();
    chk("R9 lock released by reset", {62'd0, i_lock, d_lock}, 64'd0);
    wr_ctl(1'b1, 1'b0, 1'b0);
    chk("R9 enable writable after reset", {63'd0, i_en}, 64'd1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule